// File: doc/BRIEF.md
# Row-Multiplexed Dimming Display Scanner

This block refreshes an eight-character, five-row dot-matrix LED display from a character RAM that lives outside it. Each of the five rows gets a time slot. During its slot one row-select output is driven while forty column outputs carry that row's dots for every character. The scanner advances one step per multiplex tick. The tick comes from an internal oscillator strobe or from an external multiplex clock pin, and the clock-select input picks which one. The internal strobe is always passed on to an output so that further displays can run from it.

A full frame is 320 ticks, made of five slots of 64 ticks. Brightness is set by how long the row stays lit inside its slot: k fifteenths of a 60-tick window, where k is decoded from a 3-bit level code. The last four ticks of every slot are always dark. The column register reloads only inside that dark band, so a dot is never shown with the wrong row's data. Lamp test lights every dot at the 8/15 level. Power down turns the rows off and stops the scan. Blank turns the rows off while the scan keeps running.

Top module: `disp_scanner`

## Requirements
- R1: While `rst` is high (synchronous) and in the first cycle after it, the scan sits at row 0, slot tick 0. `col_out` is all zeros, `rd_row` is 0 and lamp test is not latched.
- R2: Each accepted tick moves the slot tick from 0 to 63. Tick 63 wraps to 0 of the next row, in the order 0,1,2,3,4,0. A frame is therefore 320 ticks.
- R3: With lamp test not latched, row `r` is lit (`row_on` = 1<<r) while slot tick < 4k, where `level` 0..7 maps to k = 15, 8, 6, 4, 3, 2, 1, 0.
- R4: At most one bit of `row_on` is high, and no row is lit on slot ticks 60 to 63.
- R5: `rd_row` shows the current row on ticks 0 to 59 and the following row (4 wraps to 0) on ticks 60 to 63. The tick that enters slot tick 62 loads `rd_data` into `col_out` unchanged: bit 5*c+j is character c, column j. `col_out` changes only in a cycle where no row is lit and none was lit in the cycle before.
- R6: `lamp_test` is sampled at the same load point. While the latched value is 1, the load puts all ones into `col_out` and the duty is k = 8 whatever `level` holds.
- R7: While `power_down` is high, `row_on` is zero in the same cycle and ticks are not accepted. The scan resumes from the same row and tick when `power_down` falls.
- R8: While `blank` is high, `row_on` is zero, but ticks are still accepted and columns still load.
- R9: With `clk_sel` = 1 each `osc_tick` cycle is one tick and `ext_clk` is ignored. With `clk_sel` = 0 each rising edge of `ext_clk` is one tick, taken after a two-stage synchronizer, and `osc_tick` is ignored.
- R10: `tick_out` equals `osc_tick` delayed by one clock, whatever `clk_sel` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 1 | 1 = internal oscillator tick, 0 = external multiplex clock |
| osc_tick | input | 1 | One-cycle strobe from the internal oscillator divider |
| ext_clk | input | 1 | External multiplex clock, asynchronous |
| level | input | 3 | Brightness code, 0 brightest, 7 dark |
| lamp_test | input | 1 | Light every dot at the 8/15 level |
| power_down | input | 1 | Rows off, scan frozen |
| blank | input | 1 | Rows off, scan running |
| rd_data | input | 40 | RAM row data for `rd_row`, combinational read |
| rd_row | output | 3 | Row address on the RAM read port |
| row_on | output | 5 | One-hot row drive |
| col_out | output | 40 | Column drive for the lit row |
| tick_out | output | 1 | Internal tick passed on for cascaded displays |

## Verification
A corrupt row or tick counter shows at `row_on` and `rd_row` on the very next tick: the lit row or the lit length stops matching the arithmetic model. A stale or misplaced column load shows as a wrong `col_out` for the whole of the following slot, at most 64 ticks after the fault. A wrong duty decode shows within one slot for every level code, because the bench sweeps all eight codes over full frames. Clock source faults show as a missing advance or an extra advance after each external edge or ignored strobe.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int unsigned DEF_ROWS       = 5;
    localparam int unsigned DEF_CHARS      = 8;
    localparam int unsigned DEF_CHAR_COLS  = 5;
    localparam int unsigned DEF_SLOT_TICKS = 64;
    localparam int unsigned DEF_ON_SPAN    = 60;
    localparam int unsigned DEF_FRACS      = 15;
    localparam int unsigned LAMP_K         = 8;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } mux_src_e;

    typedef struct packed {
        logic       lamp;
        logic       pdown;
        logic       blank;
        logic [2:0] level;
    } scan_ctl_t;

    // brightness code -> lit fifteenths of the on-window
    function automatic logic [3:0] level_fifteenths(input logic [2:0] code);
        logic [3:0] k;
        case (code)
            3'd0:    k = 4'd15;
            3'd1:    k = 4'd8;
            3'd2:    k = 4'd6;
            3'd3:    k = 4'd4;
            3'd4:    k = 4'd3;
            3'd5:    k = 4'd2;
            3'd6:    k = 4'd1;
            default: k = 4'd0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mux_tick_sel.sv
module mux_tick_sel
    import scan_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_sel,
    input  logic osc_tick,
    input  logic ext_clk,
    output logic adv_tick,
    output logic tick_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev_q;
    logic                   ext_rise;
    mux_src_e               src;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_clk;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev_q <= 1'b0;
            tick_out   <= 1'b0;
        end else begin
            ext_prev_q <= sync_q[SYNC_STAGES-1];
            tick_out   <= osc_tick;
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;
    assign src      = mux_src_e'(clk_sel);

    always_comb begin
        case (src)
            SRC_INT: adv_tick = osc_tick;
            default: adv_tick = ext_rise;
        endcase
    end

    // R10
    tick_relay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(osc_tick) == tick_out);

endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int unsigned ROWS       = 5,
    parameter int unsigned SLOT_TICKS = 64,
    localparam int unsigned ROW_W     = $clog2(ROWS),
    localparam int unsigned TICK_W    = $clog2(SLOT_TICKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              freeze,
    output logic [ROW_W-1:0]  row,
    output logic [TICK_W-1:0] tick
);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SLOT_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row  <= '0;
            tick <= '0;
        end else if (adv && !freeze) begin
            if (tick == LAST_TICK) begin
                tick <= '0;
                row  <= (row == LAST_ROW) ? '0 : row + 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(row) && $stable(tick)));

    // R2
    row_range_chk: assert property (@(posedge clk) disable iff (rst)
        row <= LAST_ROW);

endmodule

// File: rtl/row_gate.sv
module row_gate
    import scan_pkg::*;
#(
    parameter int unsigned ROWS       = 5,
    parameter int unsigned SLOT_TICKS = 64,
    parameter int unsigned ON_SPAN    = 60,
    parameter int unsigned FRACS      = 15,
    localparam int unsigned ROW_W     = $clog2(ROWS),
    localparam int unsigned TICK_W    = $clog2(SLOT_TICKS),
    localparam int unsigned UNIT      = ON_SPAN / FRACS
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [TICK_W-1:0] tick,
    input  scan_ctl_t         ctl,
    output logic [ROWS-1:0]   row_on
);
    logic [3:0] k;
    int         on_len;
    logic       lit;

    always_comb begin
        k      = ctl.lamp ? 4'(LAMP_K) : level_fifteenths(ctl.level);
        on_len = int'(k) * int'(UNIT);
        lit    = !ctl.pdown && !ctl.blank && (int'(tick) < on_len);
        row_on = lit ? (ROWS'(1) << row) : '0;
    end

endmodule

// File: rtl/col_latch.sv
module col_latch #(
    parameter int unsigned ROWS       = 5,
    parameter int unsigned COLS       = 40,
    parameter int unsigned SLOT_TICKS = 64,
    parameter int unsigned ON_SPAN    = 60,
    localparam int unsigned ROW_W     = $clog2(ROWS),
    localparam int unsigned TICK_W    = $clog2(SLOT_TICKS),
    localparam int unsigned LOAD_AT   = SLOT_TICKS - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              freeze,
    input  logic [ROW_W-1:0]  row,
    input  logic [TICK_W-1:0] tick,
    input  logic              lamp_in,
    input  logic [COLS-1:0]   rd_data,
    output logic [ROW_W-1:0]  rd_row,
    output logic [COLS-1:0]   col_out,
    output logic              lamp_q
);
    logic [ROW_W-1:0] nxt_row;
    logic             load;

    assign nxt_row = (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
    assign rd_row  = (int'(tick) >= int'(ON_SPAN)) ? nxt_row : row;
    assign load    = adv && !freeze && (tick == TICK_W'(LOAD_AT));

    always_ff @(posedge clk) begin
        if (rst) begin
            col_out <= '0;
            lamp_q  <= 1'b0;
        end else if (load) begin
            lamp_q  <= lamp_in;
            col_out <= lamp_in ? '1 : rd_data;
        end
    end

    // R6
    lamp_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lamp_q) |-> ($past(tick) == TICK_W'(LOAD_AT)));

endmodule

// File: rtl/disp_scanner.sv
module disp_scanner
    import scan_pkg::*;
#(
    parameter int unsigned ROWS       = DEF_ROWS,
    parameter int unsigned CHARS      = DEF_CHARS,
    parameter int unsigned CHAR_COLS  = DEF_CHAR_COLS,
    parameter int unsigned SLOT_TICKS = DEF_SLOT_TICKS,
    parameter int unsigned ON_SPAN    = DEF_ON_SPAN,
    parameter int unsigned FRACS      = DEF_FRACS,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned COLS      = CHARS * CHAR_COLS,
    localparam int unsigned ROW_W     = $clog2(ROWS),
    localparam int unsigned TICK_W    = $clog2(SLOT_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_sel,
    input  logic             osc_tick,
    input  logic             ext_clk,
    input  logic [2:0]       level,
    input  logic             lamp_test,
    input  logic             power_down,
    input  logic             blank,
    input  logic [COLS-1:0]  rd_data,
    output logic [ROW_W-1:0] rd_row,
    output logic [ROWS-1:0]  row_on,
    output logic [COLS-1:0]  col_out,
    output logic             tick_out
);
    logic              adv;
    logic [ROW_W-1:0]  row;
    logic [TICK_W-1:0] tick;
    logic              lamp_q;
    scan_ctl_t         ctl;

    mux_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk),
        .rst      (rst),
        .clk_sel  (clk_sel),
        .osc_tick (osc_tick),
        .ext_clk  (ext_clk),
        .adv_tick (adv),
        .tick_out (tick_out)
    );

    scan_counter #(.ROWS(ROWS), .SLOT_TICKS(SLOT_TICKS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .freeze (power_down),
        .row    (row),
        .tick   (tick)
    );

    col_latch #(
        .ROWS(ROWS), .COLS(COLS), .SLOT_TICKS(SLOT_TICKS), .ON_SPAN(ON_SPAN)
    ) u_col (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .freeze  (power_down),
        .row     (row),
        .tick    (tick),
        .lamp_in (lamp_test),
        .rd_data (rd_data),
        .rd_row  (rd_row),
        .col_out (col_out),
        .lamp_q  (lamp_q)
    );

    always_comb begin
        ctl.lamp  = lamp_q;
        ctl.pdown = power_down;
        ctl.blank = blank;
        ctl.level = level;
    end

    row_gate #(
        .ROWS(ROWS), .SLOT_TICKS(SLOT_TICKS), .ON_SPAN(ON_SPAN), .FRACS(FRACS)
    ) u_gate (
        .row    (row),
        .tick   (tick),
        .ctl    (ctl),
        .row_on (row_on)
    );

    // R4
    one_row_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_on));

    // R4
    guard_band_chk: assert property (@(posedge clk) disable iff (rst)
        (row_on != '0) |-> (int'(tick) < int'(ON_SPAN)));

    // R5
    col_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (col_out != $past(col_out)) |-> (row_on == '0 && $past(row_on) == '0));

    // R7
    pdown_dark_chk: assert property (@(posedge clk) disable iff (rst)
        power_down |-> (row_on == '0));

endmodule

// File: tb/disp_scanner_bench.sv
module disp_scanner_bench;
    localparam int ROWS = 5;
    localparam int COLS = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            clk_sel = 1'b1;
    logic            osc_tick = 1'b0;
    logic            ext_clk = 1'b0;
    logic [2:0]      level = 3'd0;
    logic            lamp_test = 1'b0;
    logic            power_down = 1'b0;
    logic            blank = 1'b0;
    logic [COLS-1:0] rd_data;
    logic [2:0]      rd_row;
    logic [ROWS-1:0] row_on;
    logic [COLS-1:0] col_out;
    logic            tick_out;

    logic [COLS-1:0] ram [ROWS];

    int vectors = 0;
    int miscompares = 0;

    // expected scan model
    int              e_row = 0;
    int              e_tick = 0;
    logic [COLS-1:0] e_col = '0;
    logic            e_lamp = 1'b0;

    always #5 clk = ~clk;

    always_comb rd_data = (rd_row < 3'(ROWS)) ? ram[rd_row] : '0;

    disp_scanner u_disp_scanner (
        .clk, .rst, .clk_sel, .osc_tick, .ext_clk, .level, .lamp_test,
        .power_down, .blank, .rd_data, .rd_row, .row_on, .col_out, .tick_out
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic fill_ram(input int seed);
        for (int r = 0; r < ROWS; r++) begin
            logic [COLS-1:0] v;
            v = 40'h9c3a5e17b2 ^ {8{5'(seed * 3 + r * 7 + 1)}};
            ram[r] = (v << (r + seed % 5)) | (v >> (COLS - r - seed % 5));
        end
    endtask

    function automatic int kval();
        if (e_lamp) return 8;
        case (level)
            3'd0: return 15;
            3'd1: return 8;
            3'd2: return 6;
            3'd3: return 4;
            3'd4: return 3;
            3'd5: return 2;
            3'd6: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int nr;
        nr = (e_row + 1) % ROWS;
        if (e_tick == 61) begin
            e_lamp = lamp_test;
            e_col  = lamp_test ? '1 : ram[nr];
        end
        if (e_tick == 63) begin
            e_tick = 0;
            e_row  = nr;
        end else begin
            e_tick++;
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [ROWS-1:0] exp_on;
        int              exp_rd;
        exp_on = '0;
        if (!power_down && !blank && e_tick < 4 * kval())
            exp_on = ROWS'(1) << e_row;
        exp_rd = (e_tick >= 60) ? (e_row + 1) % ROWS : e_row;
        chk(tag, "row_on", 64'(row_on), 64'(exp_on));
        chk(tag, "rd_row", 64'(rd_row), 64'(exp_rd));
        chk(tag, "col_out", 64'(col_out), 64'(e_col));
    endtask

    // one osc strobe; scan advances only when internal source selected
    task automatic osc_pulse(input string tag);
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        chk("R10", "tick_out", 64'(tick_out), 64'd1);
        if (clk_sel && !power_down) model_step();
        check_outputs(tag);
    endtask

    // one external clock period, with a stray osc strobe in the high phase
    task automatic ext_period(input string tag, input bit stray_osc);
        @(negedge clk) ext_clk = 1'b1;
        if (stray_osc) begin
            osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        if (!clk_sel && !power_down) model_step();
        check_outputs(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        fill_ram(0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "col_out", 64'(col_out), 64'd0);
        chk("R1", "rd_row", 64'(rd_row), 64'd0);
        check_outputs("R1");

        // R2 R3 R5: full frames at every level code
        for (int code = 0; code < 8; code++) begin
            level = 3'(code);
            fill_ram(code + 1);
            for (int t = 0; t < 320; t++) osc_pulse("R3");
        end

        // R6: lamp test with the darkest code, raised mid-slot
        level = 3'd7;
        for (int t = 0; t < 30; t++) osc_pulse("R6");
        lamp_test = 1'b1;
        for (int t = 0; t < 400; t++) osc_pulse("R6");
        lamp_test = 1'b0;
        level = 3'd2;
        for (int t = 0; t < 140; t++) osc_pulse("R6");

        // R7: power down freezes and darkens, then resumes
        level = 3'd0;
        for (int t = 0; t < 17; t++) osc_pulse("R2");
        @(negedge clk) power_down = 1'b1;
        @(negedge clk);
        check_outputs("R7");
        for (int t = 0; t < 80; t++) osc_pulse("R7");
        power_down = 1'b0;
        for (int t = 0; t < 120; t++) osc_pulse("R7");

        // R8: blank keeps the scan and column loads running
        blank = 1'b1;
        fill_ram(11);
        for (int t = 0; t < 130; t++) osc_pulse("R8");
        blank = 1'b0;
        for (int t = 0; t < 70; t++) osc_pulse("R8");

        // R9: external source, stray osc strobes ignored
        @(negedge clk) clk_sel = 1'b0;
        level = 3'd1;
        for (int t = 0; t < 150; t++) ext_period("R9", (t % 3) == 0);
        for (int t = 0; t < 5; t++) osc_pulse("R9");
        // R9: back to internal, external edges ignored
        @(negedge clk) clk_sel = 1'b1;
        for (int t = 0; t < 5; t++) ext_period("R9", 1'b0);
        for (int t = 0; t < 70; t++) osc_pulse("R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule